// File: doc/BRIEF.md
# Dual-Mode Half-Word Sample Deframer

This block sits behind the capture stage of a double-rate source-synchronous receive port. The capture stage has already turned the rising-edge and falling-edge words into one single-rate stream: one word per clock, carrying a 6-lane data half-word and one frame bit. The deframer finds the sample boundaries from the duty pattern of the frame bit and joins the half-words back into 12-bit in-phase and quadrature samples.

A mode input picks one of two framings. In two-channel mode each 8-word period holds one sample of channel 0 and then one of channel 1, and both pairs come out together on one strobe. In single-channel mode each 8-word period holds two successive samples of one channel. Each sample is presented on both output pairs, and the strobe runs at twice the two-channel rate. A per-lane inversion mask and a frame inversion bit fix board-level polarity swaps before any decoding takes place.

Lock is declared once the expected frame pattern has been seen for a set number of whole periods. Any frame bit that departs from the pattern drops lock and restarts the search. While unlocked the outputs hold their last values and no strobe is raised.

Top module: `ddr_sample_deframer`

## Requirements
- R1: Within each 4-word group, after inversion, the words carry in order the upper six bits of I, the upper six bits of Q, the lower six bits of I and the lower six bits of Q.
- R2: In two-channel mode (`mimo_mode`=1) the frame bit over one 8-word period must read 1,1,1,1,0,0,0,0. A rising frame edge starts the period. `aligned_o` rises in the cycle after the last word of the LOCK_PERIODS-th consecutive matching period (default 2).
- R3: In single-channel mode (`mimo_mode`=0) the frame bit over one 8-word period must read 1,1,0,0,1,1,0,0. Lock is counted the same way as in R2.
- R4: In two-channel mode, while locked, `strobe_o` pulses for one cycle in the cycle after word 8 of each period. `ch0_i_o`/`ch0_q_o` then show the sample from words 1 to 4 and `ch1_i_o`/`ch1_q_o` show the sample from words 5 to 8.
- R5: In single-channel mode, while locked, `strobe_o` pulses in the cycle after word 4 and after word 8. Both output pairs show the sample just completed.
- R6: A frame bit that differs from the expected pattern while tracking clears `aligned_o` in the next cycle, suppresses the strobe for that word and restarts the search for a rising frame edge.
- R7: When `strobe_o` is low all four sample outputs hold their previous values, and no strobe is raised unless the block was locked before the word that ends the sample.
- R8: Synchronous active-high `rst` clears `aligned_o`, `strobe_o` and all sample outputs to zero. Lock must then be acquired again from a new rising frame edge.
- R9: Each lane is XORed with bit k of parameter INV_DATA, and the frame with INV_FRAME, before alignment and assembly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, one captured word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mimo_mode | input | 1 | 1 selects two-channel framing, 0 selects single-channel framing |
| lane_in | input | LANES (6) | Captured data half-word |
| frame_in | input | 1 | Captured frame bit |
| aligned_o | output | 1 | Lock to the frame pattern |
| strobe_o | output | 1 | One-cycle pulse when new samples are presented |
| ch0_i_o | output | 12 | Channel 0 in-phase sample |
| ch0_q_o | output | 12 | Channel 0 quadrature sample |
| ch1_i_o | output | 12 | Channel 1 in-phase sample (copy of channel 0 in single-channel mode) |
| ch1_q_o | output | 12 | Channel 1 quadrature sample (copy of channel 0 in single-channel mode) |

## Verification
Two functions can fall in the same cycle: pattern checking and the emission of a completed sample. Both act on the word that ends a period. The bench corrupts the frame bit on word 8 of a locked two-channel period, so the mismatch lands on the very word that would trigger a strobe. It then expects `aligned_o` low, no strobe, and sample outputs still holding the previous period's values. The same pressure arises on the last word of the lock-counting period, where lock is declared and no strobe may yet appear. A behavioural model judges every clock, and targeted checks read the exact sample values.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    localparam int LANES  = 6;
    localparam int SAMP_W = 2 * LANES;
    localparam int PERIOD = 8;
    localparam int PH_W   = $clog2(PERIOD);

    typedef struct packed {
        logic [SAMP_W-1:0] i;
        logic [SAMP_W-1:0] q;
    } samp_t;

    typedef enum logic {
        SEEK  = 1'b0,
        TRACK = 1'b1
    } trk_e;

    // Expected frame level at a word position for the chosen framing.
    function automatic logic frame_expect(input logic mimo, input logic [PH_W-1:0] ph);
        return mimo ? ~ph[2] : ~ph[1];
    endfunction

endpackage

// File: rtl/dfr_align.sv
module dfr_align
    import dfr_pkg::*;
#(
    parameter int LOCK_PERIODS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mimo,
    input  logic            frame_i,
    output logic [PH_W-1:0] cur_ph,
    output logic            slot_ok,
    output logic            aligned
);

    localparam int CW = $clog2(LOCK_PERIODS + 1);

    trk_e            state;
    logic [PH_W-1:0] ph;
    logic [CW-1:0]   cnt;
    logic            prev_f;
    logic            hit;
    logic            match;
    logic            last_word;

    assign hit       = (state == SEEK) && frame_i && !prev_f;
    assign match     = (state == TRACK) && (frame_i == frame_expect(mimo, ph));
    assign last_word = (ph == PH_W'(PERIOD - 1));
    assign cur_ph    = (state == TRACK) ? ph : '0;
    assign slot_ok   = match;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEEK;
            ph      <= '0;
            cnt     <= '0;
            prev_f  <= 1'b0;
            aligned <= 1'b0;
        end else begin
            prev_f <= frame_i;
            if (state == SEEK) begin
                if (hit) begin
                    state <= TRACK;
                    ph    <= PH_W'(1);
                    cnt   <= '0;
                end
            end else if (!match) begin
                state   <= SEEK;
                ph      <= '0;
                cnt     <= '0;
                aligned <= 1'b0;
            end else begin
                ph <= ph + PH_W'(1);
                if (last_word) begin
                    if (cnt != CW'(LOCK_PERIODS)) cnt <= cnt + CW'(1);
                    if (cnt + CW'(1) >= CW'(LOCK_PERIODS)) aligned <= 1'b1;
                end
            end
        end
    end

    // R2 R3: lock is only declared on the last word of a matching period.
    assert_lock_at_period_end_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> $past(state == TRACK && ph == PH_W'(PERIOD - 1)));

    // R6: a departure from the pattern drops lock and returns to search.
    assert_mismatch_drops_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (state == TRACK && !match) |=> (!aligned && state == SEEK));

    // R3: word position advances by one on each matching word.
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == TRACK && match && ph != PH_W'(PERIOD - 1)) |=> (ph == PH_W'($past(ph) + PH_W'(1))));

    // R8: search starts only from a rising frame edge.
    assert_track_needs_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SEEK && !hit) |=> (state == SEEK));

endmodule

// File: rtl/dfr_assemble.sv
module dfr_assemble
    import dfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  cur_ph,
    input  logic [LANES-1:0] word,
    output samp_t            samp,
    output logic             done
);

    logic [LANES-1:0] i_hi;
    logic [LANES-1:0] q_hi;
    logic [LANES-1:0] i_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            i_hi <= '0;
            q_hi <= '0;
            i_lo <= '0;
        end else begin
            case (cur_ph[1:0])
                2'd0:    i_hi <= word;
                2'd1:    q_hi <= word;
                2'd2:    i_lo <= word;
                default: ;
            endcase
        end
    end

    assign done   = (cur_ph[1:0] == 2'd3);
    assign samp.i = {i_hi, i_lo};
    assign samp.q = {q_hi, word};

endmodule

// File: rtl/dfr_route.sv
module dfr_route
    import dfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mimo,
    input  logic              slot_emit,
    input  logic              done,
    input  logic              second_half,
    input  samp_t             samp,
    output samp_t             ch0,
    output samp_t             ch1,
    output logic              strobe
);

    samp_t pend;
    logic  emit;

    assign emit = slot_emit && (!mimo || second_half);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            ch0    <= '0;
            ch1    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= emit;
            if (done && !second_half) pend <= samp;
            if (emit) begin
                ch0 <= mimo ? pend : samp;
                ch1 <= samp;
            end
        end
    end

    // R5: single-channel strobes carry identical pairs.
    assert_siso_duplicate_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe && !$past(mimo)) |-> (ch0 == ch1));

    // R7: outputs hold between strobes.
    assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> ($stable(ch0) && $stable(ch1)));

endmodule

// File: rtl/ddr_sample_deframer.sv
module ddr_sample_deframer
    import dfr_pkg::*;
#(
    parameter logic [LANES-1:0] INV_DATA     = '0,
    parameter logic             INV_FRAME    = 1'b0,
    parameter int               LOCK_PERIODS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mimo_mode,
    input  logic [LANES-1:0]  lane_in,
    input  logic              frame_in,
    output logic              aligned_o,
    output logic              strobe_o,
    output logic [SAMP_W-1:0] ch0_i_o,
    output logic [SAMP_W-1:0] ch0_q_o,
    output logic [SAMP_W-1:0] ch1_i_o,
    output logic [SAMP_W-1:0] ch1_q_o
);

    logic [LANES-1:0] word;
    logic             frame;
    logic [PH_W-1:0]  cur_ph;
    logic             slot_ok;
    logic             aligned;
    samp_t            samp;
    logic             done;
    samp_t            ch0;
    samp_t            ch1;

    // Per-lane polarity correction.
    for (genvar k = 0; k < LANES; k++) begin : g_lane_pol
        assign word[k] = lane_in[k] ^ INV_DATA[k];
    end
    assign frame = frame_in ^ INV_FRAME;

    dfr_align #(.LOCK_PERIODS(LOCK_PERIODS)) u_align (
        .clk     (clk),
        .rst     (rst),
        .mimo    (mimo_mode),
        .frame_i (frame),
        .cur_ph  (cur_ph),
        .slot_ok (slot_ok),
        .aligned (aligned)
    );

    dfr_assemble u_asm (
        .clk    (clk),
        .rst    (rst),
        .cur_ph (cur_ph),
        .word   (word),
        .samp   (samp),
        .done   (done)
    );

    dfr_route u_route (
        .clk         (clk),
        .rst         (rst),
        .mimo        (mimo_mode),
        .slot_emit   (aligned && slot_ok && done),
        .done        (done),
        .second_half (cur_ph[2]),
        .samp        (samp),
        .ch0         (ch0),
        .ch1         (ch1),
        .strobe      (strobe_o)
    );

    assign aligned_o = aligned;
    assign ch0_i_o   = ch0.i;
    assign ch0_q_o   = ch0.q;
    assign ch1_i_o   = ch1.i;
    assign ch1_q_o   = ch1.q;

    // R7: no strobe without lock in the cycle before.
    assert_strobe_needs_lock_R7: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> $past(aligned));

    // R4: two-channel strobes only follow the second half of a period.
    assert_mimo_strobe_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(mimo_mode)) |-> ($past(cur_ph) == PH_W'(PERIOD - 1)));

endmodule

// File: tb/ddr_sample_deframer_tb.sv
`timescale 1ns/1ps
module ddr_sample_deframer_tb;

    localparam logic [5:0] INVD = 6'b101001;
    localparam logic       INVF = 1'b1;
    localparam int         LOCKN = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mimo_mode = 1'b1;
    logic [5:0]  lane_in = '0;
    logic        frame_in = INVF;
    logic        aligned_o, strobe_o;
    logic [11:0] ch0_i_o, ch0_q_o, ch1_i_o, ch1_q_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ddr_sample_deframer #(.INV_DATA(INVD), .INV_FRAME(INVF), .LOCK_PERIODS(LOCKN)) u_dut (
        .clk(clk), .rst(rst), .mimo_mode(mimo_mode), .lane_in(lane_in), .frame_in(frame_in),
        .aligned_o(aligned_o), .strobe_o(strobe_o),
        .ch0_i_o(ch0_i_o), .ch0_q_o(ch0_q_o), .ch1_i_o(ch1_i_o), .ch1_q_o(ch1_q_o)
    );

    // Behavioural reference model
    int  m_trk = 0, m_ph = 0, m_cnt = 0, m_pf = 0, m_al = 0;
    int  hw[4] = '{0, 0, 0, 0};
    int  pend_i = 0, pend_q = 0;
    int  e_stb = 0, e0i = 0, e0q = 0, e1i = 0, e1q = 0;
    bit  started = 0;

    always @(posedge clk) begin
        int f, d, pos, si, sq, expb;
        started = 1;
        if (rst) begin
            m_trk = 0; m_ph = 0; m_cnt = 0; m_pf = 0; m_al = 0;
            hw = '{0, 0, 0, 0}; pend_i = 0; pend_q = 0;
            e_stb = 0; e0i = 0; e0q = 0; e1i = 0; e1q = 0;
        end else begin
            f = int'(frame_in ^ INVF);
            d = int'(lane_in ^ INVD);
            pos = m_trk ? m_ph : 0;
            hw[pos % 4] = d;
            si = hw[0] * 64 + hw[2];
            sq = hw[1] * 64 + hw[3];
            e_stb = 0;
            if (m_trk == 0) begin
                if (f == 1 && m_pf == 0) begin m_trk = 1; m_ph = 1; m_cnt = 0; end
            end else begin
                expb = mimo_mode ? (m_ph < 4) : ((m_ph % 4) < 2);
                if (f != expb) begin
                    m_trk = 0; m_ph = 0; m_cnt = 0; m_al = 0;
                end else begin
                    if (m_al == 1 && pos % 4 == 3 && (!mimo_mode || pos == 7)) begin
                        e_stb = 1;
                        e1i = si; e1q = sq;
                        if (mimo_mode) begin e0i = pend_i; e0q = pend_q; end
                        else begin e0i = si; e0q = sq; end
                    end
                    if (m_ph == 7) begin
                        if (m_cnt < LOCKN) m_cnt++;
                        if (m_cnt >= LOCKN) m_al = 1;
                    end
                    m_ph = (m_ph + 1) % 8;
                end
            end
            if (pos == 3) begin pend_i = si; pend_q = sq; end
            m_pf = f;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (aligned_o !== (m_al != 0) || strobe_o !== (e_stb != 0)) begin
                n_bad++;
                $display("FAIL R2 R3 R6 R8 control: aligned=%0b strobe=%0b expected aligned=%0d strobe=%0d",
                         aligned_o, strobe_o, m_al, e_stb);
            end
            n_chk++;
            if (ch0_i_o !== 12'(e0i) || ch0_q_o !== 12'(e0q) || ch1_i_o !== 12'(e1i) || ch1_q_o !== 12'(e1q)) begin
                n_bad++;
                $display("FAIL R1 R4 R5 R7 R9 data: %h %h %h %h expected %h %h %h %h",
                         ch0_i_o, ch0_q_o, ch1_i_o, ch1_q_o, 12'(e0i), 12'(e0q), 12'(e1i), 12'(e1q));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [5:0] w, input logic f);
        @(negedge clk);
        lane_in  = w ^ INVD;
        frame_in = f ^ INVF;
    endtask

    task automatic send_half(input logic [11:0] si, input logic [11:0] sq, input logic [3:0] pat);
        send_word(si[11:6], pat[3]);
        send_word(sq[11:6], pat[2]);
        send_word(si[5:0],  pat[1]);
        send_word(sq[5:0],  pat[0]);
    endtask

    task automatic send_period(input logic [11:0] a, input logic [11:0] b,
                               input logic [11:0] c, input logic [11:0] e, input logic [7:0] pat);
        send_half(a, b, pat[7:4]);
        send_half(c, e, pat[3:0]);
    endtask

    task automatic mperiod(input int n, input logic [7:0] pat);
        send_period(12'hA00 + 12'(n), 12'hB00 + 12'(n), 12'hC00 + 12'(n), 12'hD00 + 12'(n), pat);
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input int cyc);
        @(negedge clk); rst = 1'b1;
        repeat (cyc) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 reset aligned", 32'(aligned_o), 0);
        chk("R8 reset outputs", 32'(ch0_i_o | ch1_q_o), 0);

        // Two-channel lock
        mimo_mode = 1'b1;
        repeat (3) send_word(6'h00, 1'b0);
        mperiod(0, 8'hF0);
        mperiod(1, 8'hF0); settle();
        chk("R2 lock after two periods", 32'(aligned_o), 1);
        chk("R2 no strobe on lock word", 32'(strobe_o), 0);
        mperiod(2, 8'hF0); settle();
        chk("R4 strobe", 32'(strobe_o), 1);
        chk("R4 R1 R9 ch0 I", 32'(ch0_i_o), 32'h0A02);
        chk("R4 R1 R9 ch0 Q", 32'(ch0_q_o), 32'h0B02);
        chk("R4 R1 ch1 I", 32'(ch1_i_o), 32'h0C02);
        chk("R4 R1 ch1 Q", 32'(ch1_q_o), 32'h0D02);

        // Corrupt word 8: mismatch on the emitting word
        mperiod(3, 8'hF1); settle();
        chk("R6 lock dropped", 32'(aligned_o), 0);
        chk("R6 strobe suppressed", 32'(strobe_o), 0);
        chk("R7 outputs held", 32'(ch1_q_o), 32'h0D02);
        mperiod(4, 8'hF0);
        mperiod(5, 8'hF0); settle();
        chk("R6 search restarted, not yet locked", 32'(aligned_o), 0);
        mperiod(6, 8'hF0); settle();
        chk("R2 relock", 32'(aligned_o), 1);
        mperiod(7, 8'hF0); settle();
        chk("R4 ch1 Q after relock", 32'(ch1_q_o), 32'h0D07);

        // Reset mid-stream
        do_reset(3); #1;
        chk("R8 aligned cleared", 32'(aligned_o), 0);
        chk("R8 outputs cleared", 32'(ch0_i_o), 0);
        mperiod(8, 8'hF0); settle();
        chk("R8 reacquire in progress", 32'(aligned_o), 0);
        mperiod(9, 8'hF0); settle();
        chk("R8 reacquired", 32'(aligned_o), 1);

        // Single-channel framing
        mimo_mode = 1'b0;
        repeat (3) send_word(6'h00, 1'b0);
        settle();
        chk("R6 lock lost on idle", 32'(aligned_o), 0);
        send_period(12'h111, 12'h222, 12'h333, 12'h444, 8'hCC);
        send_period(12'h155, 12'h266, 12'h377, 12'h488, 8'hCC); settle();
        chk("R3 single-channel lock", 32'(aligned_o), 1);
        send_half(12'h5A5, 12'h6C3, 4'hC); settle();
        chk("R5 strobe at word 4", 32'(strobe_o), 1);
        chk("R5 ch0 I", 32'(ch0_i_o), 32'h05A5);
        chk("R5 ch1 I duplicate", 32'(ch1_i_o), 32'h05A5);
        chk("R5 ch1 Q duplicate", 32'(ch1_q_o), 32'h06C3);
        send_half(12'h7E1, 12'h83F, 4'hC); settle();
        chk("R5 strobe at word 8", 32'(strobe_o), 1);
        chk("R5 ch0 Q", 32'(ch0_q_o), 32'h083F);
        chk("R5 ch1 I", 32'(ch1_i_o), 32'h07E1);
        send_word(6'h3F, 1'b1); settle();
        chk("R7 no strobe mid-sample", 32'(strobe_o), 0);
        chk("R7 hold", 32'(ch0_i_o), 32'h07E1);
        repeat (6) send_word(6'h00, 1'b0);
        settle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule